// File: doc/BRIEF.md
# Non-Blocking L1 Load Cache with Miss Tracking Table

This block is the front end of a set-associative first-level data cache that serves coalesced global loads, one 128-byte block per cycle. A block is 32 lanes of 32 bits each, one word per bank. An incoming request is accepted or rejected in the cycle it is presented. An accepted hit returns the block one cycle later, and only the lanes the request marks active carry data. A miss never stalls the requester. Instead the block tells the requester to replay, records the miss in a pending-request table and issues a memory request. That request carries a sub-identifier equal to the index of its table entry.

When memory answers, the fill path uses the sub-identifier to find the table entry. It writes the line into the data array, marks the line locked and announces a reschedule carrying the original block address and lane mask. The requester reissues the load with its reschedule flag set. Because the line is locked, that reissued load is certain to hit, and the hit releases the lock. A way is busy while it is locked or waiting for a fill. A miss is refused when the target set has no free way, when the table is full, or when the same block is already outstanding. Hits are always accepted.

Top module: `l1_prt_cache`

## Requirements
- R1: Every presented request receives exactly one of req_accept_o and req_reject_o in the same cycle. A request that hits is always accepted, even while the table is full. A rejected request causes no writeback, no replay and no memory request.
- R2: An accepted hit raises wb_valid_o exactly one cycle later with the cached block. Lane l occupies bits [32l+31:32l].
- R3: In wb_data_o, lanes whose request mask bit is 0 read as zero, and wb_mask_o equals the request mask.
- R4: An accepted miss raises replay_o and mem_req_valid_o one cycle later. mem_req_addr_o is the block-aligned address (low 7 bits zero). mem_req_subid_o is the lowest-numbered free table entry. With the default 16 sets, the set index is address bits [10:7].
- R5: A miss is rejected while all 8 table entries are outstanding.
- R6: A miss is rejected while every one of the 4 ways of its set is locked or awaiting a fill.
- R7: A miss to a block that already has an outstanding table entry is rejected, not merged.
- R8: A response whose sub-identifier names an outstanding entry raises resched_valid_o one cycle later, carrying that entry's block address and lane mask. A following request with req_resched_i=1 for that block is accepted and hits with the response data.
- R9: A filled line is locked and cannot be chosen as a victim until a hit with req_resched_i=1 releases it.
- R10: The victim of a miss is the lowest-numbered way that is neither locked nor awaiting a fill.
- R11: A response whose sub-identifier names no outstanding entry is ignored and produces no reschedule.
- R12: After reset, no output is asserted and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Load request present |
| req_addr_i | input | ADDR_W | Byte address of the load |
| req_mask_i | input | LANES | Active-lane mask |
| req_resched_i | input | 1 | Request is the reissue of a filled miss |
| req_accept_o | output | 1 | Request taken this cycle |
| req_reject_o | output | 1 | Request refused this cycle; retry later |
| wb_valid_o | output | 1 | Hit data valid for register writeback |
| wb_mask_o | output | LANES | Lanes to write back |
| wb_data_o | output | LANES*WORD_W | Block data, inactive lanes zero |
| replay_o | output | 1 | Previous accepted request missed; replay it |
| mem_req_valid_o | output | 1 | Memory read request |
| mem_req_addr_o | output | ADDR_W | Block-aligned address of the memory read |
| mem_req_subid_o | output | $clog2(PRT_N) | Table entry that tracks the read |
| mem_rsp_valid_i | input | 1 | Memory response present |
| mem_rsp_subid_i | input | $clog2(PRT_N) | Table entry the response belongs to |
| mem_rsp_data_i | input | LANES*WORD_W | Returned block |
| resched_valid_o | output | 1 | A filled load may be reissued |
| resched_addr_o | output | ADDR_W | Block address of the filled load |
| resched_mask_o | output | LANES | Lane mask of the filled load |

## Verification
The bench builds the block with its defaults: 32 lanes of 32 bits, 16 sets, 4 ways and 8 table entries. Random traffic is confined to twelve blocks spread over two sets, so with only four ways each, those sets are regularly fully locked or pending and the busy-set rejection happens often. Eight entries are few enough that the directed sequence fills the table in a handful of misses to show the full-table rejection. The same sequence then shows a hit accepted while the table is full and the eviction order of way 0 against way 1. Responses come back out of order after random delays, which exercises sub-identifier reuse.

// File: rtl/l1p_pkg.sv
package l1p_pkg;
  typedef enum logic [1:0] {
    OUT_NONE = 2'd0,
    OUT_HIT  = 2'd1,
    OUT_MISS = 2'd2
  } s1_kind_e;
endpackage

// File: rtl/l1p_tag_array.sv
module l1p_tag_array #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int TAG_W = 21
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [$clog2(SETS)-1:0]  lk_set_i,
  input  logic [TAG_W-1:0]         lk_tag_i,
  output logic                     hit_o,
  output logic [$clog2(WAYS)-1:0]  hit_way_o,
  output logic                     free_o,
  output logic [$clog2(WAYS)-1:0]  victim_o,
  input  logic                     miss_we_i,
  input  logic [$clog2(SETS)-1:0]  miss_set_i,
  input  logic [$clog2(WAYS)-1:0]  miss_way_i,
  input  logic                     fill_we_i,
  input  logic [$clog2(SETS)-1:0]  fill_set_i,
  input  logic [$clog2(WAYS)-1:0]  fill_way_i,
  input  logic [TAG_W-1:0]         fill_tag_i,
  input  logic                     unlock_we_i,
  input  logic [$clog2(SETS)-1:0]  unlock_set_i,
  input  logic [$clog2(WAYS)-1:0]  unlock_way_i
);
  localparam int WAY_W = $clog2(WAYS);

  logic [SETS-1:0][WAYS-1:0] vld_q, lock_q, pend_q;
  logic [TAG_W-1:0]          tag_q [SETS][WAYS];

  // lowest way wins: scan downward
  always_comb begin
    hit_o     = 1'b0;
    hit_way_o = '0;
    free_o    = 1'b0;
    victim_o  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (vld_q[lk_set_i][w] && (tag_q[lk_set_i][w] == lk_tag_i)) begin
        hit_o     = 1'b1;
        hit_way_o = WAY_W'(w);
      end
      if (!lock_q[lk_set_i][w] && !pend_q[lk_set_i][w]) begin
        free_o   = 1'b1;
        victim_o = WAY_W'(w);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      lock_q <= '0;
      pend_q <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          if (miss_we_i && miss_set_i == s[$clog2(SETS)-1:0] && miss_way_i == w[WAY_W-1:0]) begin
            pend_q[s][w] <= 1'b1;
            vld_q[s][w]  <= 1'b0;
          end
          if (fill_we_i && fill_set_i == s[$clog2(SETS)-1:0] && fill_way_i == w[WAY_W-1:0]) begin
            pend_q[s][w] <= 1'b0;
            vld_q[s][w]  <= 1'b1;
            lock_q[s][w] <= 1'b1;
          end
          if (unlock_we_i && unlock_set_i == s[$clog2(SETS)-1:0] && unlock_way_i == w[WAY_W-1:0])
            lock_q[s][w] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_we_i) tag_q[fill_set_i][fill_way_i] <= fill_tag_i;
  end

  a_r10_victim_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_we_i |-> (!lock_q[miss_set_i][miss_way_i] && !pend_q[miss_set_i][miss_way_i]));
  a_r9_lock_pend_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q & pend_q) == '0);
  a_r8_fill_was_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_we_i |-> pend_q[fill_set_i][fill_way_i]);
endmodule

// File: rtl/l1p_prt.sv
module l1p_prt #(
  parameter int N     = 8,
  parameter int BA_W  = 25,
  parameter int WAY_W = 2,
  parameter int LANES = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [BA_W-1:0]      lk_ba_i,
  output logic                 match_o,
  output logic                 full_o,
  output logic [$clog2(N)-1:0] alloc_idx_o,
  input  logic                 alloc_i,
  input  logic [BA_W-1:0]      alloc_ba_i,
  input  logic [WAY_W-1:0]     alloc_way_i,
  input  logic [LANES-1:0]     alloc_mask_i,
  input  logic                 free_i,
  input  logic [$clog2(N)-1:0] rd_idx_i,
  output logic                 rd_live_o,
  output logic [BA_W-1:0]      rd_ba_o,
  output logic [WAY_W-1:0]     rd_way_o,
  output logic [LANES-1:0]     rd_mask_o
);
  localparam int IDX_W = $clog2(N);

  logic [N-1:0]     live_q;
  logic [BA_W-1:0]  ba_q   [N];
  logic [WAY_W-1:0] way_q  [N];
  logic [LANES-1:0] mask_q [N];

  always_comb begin
    match_o     = 1'b0;
    alloc_idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (live_q[i] && ba_q[i] == lk_ba_i) match_o = 1'b1;
      if (!live_q[i]) alloc_idx_o = IDX_W'(i);
    end
  end

  assign full_o    = &live_q;
  assign rd_live_o = live_q[rd_idx_i];
  assign rd_ba_o   = ba_q[rd_idx_i];
  assign rd_way_o  = way_q[rd_idx_i];
  assign rd_mask_o = mask_q[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= '0;
    end else begin
      if (alloc_i) live_q[alloc_idx_o] <= 1'b1;
      if (free_i && rd_live_o) live_q[rd_idx_i] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (alloc_i) begin
      ba_q[alloc_idx_o]   <= alloc_ba_i;
      way_q[alloc_idx_o]  <= alloc_way_i;
      mask_q[alloc_idx_o] <= alloc_mask_i;
    end
  end

  a_r5_alloc_not_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !full_o);
  a_r7_alloc_no_dup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !match_o);
  a_r4_alloc_was_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |=> live_q[$past(alloc_idx_o)]);
endmodule

// File: rtl/l1p_data_array.sv
module l1p_data_array #(
  parameter int DEPTH = 64,
  parameter int W     = 1024
) (
  input  logic                     clk_i,
  input  logic                     rd_en_i,
  input  logic [$clog2(DEPTH)-1:0] rd_idx_i,
  output logic [W-1:0]             rd_data_o,
  input  logic                     wr_en_i,
  input  logic [$clog2(DEPTH)-1:0] wr_idx_i,
  input  logic [W-1:0]             wr_data_i
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
    if (rd_en_i) rd_data_o <= mem_q[rd_idx_i];
  end
endmodule

// File: rtl/l1_prt_cache.sv
module l1_prt_cache
  import l1p_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LANES  = 32,
  parameter int WORD_W = 32,
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int PRT_N  = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  input  logic [ADDR_W-1:0]         req_addr_i,
  input  logic [LANES-1:0]          req_mask_i,
  input  logic                      req_resched_i,
  output logic                      req_accept_o,
  output logic                      req_reject_o,
  output logic                      wb_valid_o,
  output logic [LANES-1:0]          wb_mask_o,
  output logic [LANES*WORD_W-1:0]   wb_data_o,
  output logic                      replay_o,
  output logic                      mem_req_valid_o,
  output logic [ADDR_W-1:0]         mem_req_addr_o,
  output logic [$clog2(PRT_N)-1:0]  mem_req_subid_o,
  input  logic                      mem_rsp_valid_i,
  input  logic [$clog2(PRT_N)-1:0]  mem_rsp_subid_i,
  input  logic [LANES*WORD_W-1:0]   mem_rsp_data_i,
  output logic                      resched_valid_o,
  output logic [ADDR_W-1:0]         resched_addr_o,
  output logic [LANES-1:0]          resched_mask_o
);
  localparam int LINE_W = LANES * WORD_W;
  localparam int OFF_W  = $clog2(LINE_W / 8);
  localparam int SET_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int IDX_W  = $clog2(PRT_N);
  localparam int BA_W   = ADDR_W - OFF_W;
  localparam int TAG_W  = BA_W - SET_W;
  localparam int DEPTH  = SETS * WAYS;

  logic [BA_W-1:0]  req_ba;
  logic [SET_W-1:0] req_set;
  logic             tag_hit, way_free;
  logic [WAY_W-1:0] hit_way, victim;
  logic             prt_match, prt_full;
  logic [IDX_W-1:0] prt_idx;
  logic             rsp_live;
  logic [BA_W-1:0]  rsp_ba;
  logic [WAY_W-1:0] rsp_way;
  logic [LANES-1:0] rsp_mask;
  logic             do_hit, do_miss, do_fill;
  logic [LINE_W-1:0] rd_line;

  s1_kind_e         s1_kind_q;
  logic [LANES-1:0] s1_mask_q;

  assign req_ba  = req_addr_i[ADDR_W-1:OFF_W];
  assign req_set = req_ba[SET_W-1:0];

  // hits always pass; a miss needs a way, an entry and no twin
  assign do_hit       = req_valid_i && tag_hit;
  assign do_miss      = req_valid_i && !tag_hit && way_free && !prt_full && !prt_match;
  assign req_accept_o = do_hit || do_miss;
  assign req_reject_o = req_valid_i && !req_accept_o;
  assign do_fill      = mem_rsp_valid_i && rsp_live;

  l1p_tag_array #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) tags_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lk_set_i     (req_set),
    .lk_tag_i     (req_ba[BA_W-1:SET_W]),
    .hit_o        (tag_hit),
    .hit_way_o    (hit_way),
    .free_o       (way_free),
    .victim_o     (victim),
    .miss_we_i    (do_miss),
    .miss_set_i   (req_set),
    .miss_way_i   (victim),
    .fill_we_i    (do_fill),
    .fill_set_i   (rsp_ba[SET_W-1:0]),
    .fill_way_i   (rsp_way),
    .fill_tag_i   (rsp_ba[BA_W-1:SET_W]),
    .unlock_we_i  (do_hit && req_resched_i),
    .unlock_set_i (req_set),
    .unlock_way_i (hit_way)
  );

  l1p_prt #(.N(PRT_N), .BA_W(BA_W), .WAY_W(WAY_W), .LANES(LANES)) prt_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lk_ba_i      (req_ba),
    .match_o      (prt_match),
    .full_o       (prt_full),
    .alloc_idx_o  (prt_idx),
    .alloc_i      (do_miss),
    .alloc_ba_i   (req_ba),
    .alloc_way_i  (victim),
    .alloc_mask_i (req_mask_i),
    .free_i       (mem_rsp_valid_i),
    .rd_idx_i     (mem_rsp_subid_i),
    .rd_live_o    (rsp_live),
    .rd_ba_o      (rsp_ba),
    .rd_way_o     (rsp_way),
    .rd_mask_o    (rsp_mask)
  );

  l1p_data_array #(.DEPTH(DEPTH), .W(LINE_W)) data_i (
    .clk_i     (clk_i),
    .rd_en_i   (do_hit),
    .rd_idx_i  ({req_set, hit_way}),
    .rd_data_o (rd_line),
    .wr_en_i   (do_fill),
    .wr_idx_i  ({rsp_ba[SET_W-1:0], rsp_way}),
    .wr_data_i (mem_rsp_data_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_kind_q       <= OUT_NONE;
      s1_mask_q       <= '0;
      mem_req_valid_o <= 1'b0;
      mem_req_addr_o  <= '0;
      mem_req_subid_o <= '0;
      resched_valid_o <= 1'b0;
      resched_addr_o  <= '0;
      resched_mask_o  <= '0;
    end else begin
      s1_kind_q       <= do_hit ? OUT_HIT : (do_miss ? OUT_MISS : OUT_NONE);
      s1_mask_q       <= req_mask_i;
      mem_req_valid_o <= do_miss;
      if (do_miss) begin
        mem_req_addr_o  <= {req_ba, {OFF_W{1'b0}}};
        mem_req_subid_o <= prt_idx;
      end
      resched_valid_o <= do_fill;
      if (do_fill) begin
        resched_addr_o <= {rsp_ba, {OFF_W{1'b0}}};
        resched_mask_o <= rsp_mask;
      end
    end
  end

  assign wb_valid_o = (s1_kind_q == OUT_HIT);
  assign replay_o   = (s1_kind_q == OUT_MISS);
  assign wb_mask_o  = wb_valid_o ? s1_mask_q : '0;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign wb_data_o[l*WORD_W +: WORD_W] =
      (wb_valid_o && s1_mask_q[l]) ? rd_line[l*WORD_W +: WORD_W] : '0;
  end

  a_r1_one_answer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> (req_accept_o ^ req_reject_o));
  a_r1_hit_accepted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && tag_hit) |-> req_accept_o);
  a_r2_hit_writeback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && tag_hit) |=> (wb_valid_o && !replay_o));
  a_r4_miss_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_accept_o && !tag_hit) |=> (mem_req_valid_o && replay_o && !wb_valid_o));
  a_r8_fill_resched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rsp_valid_i && rsp_live) |=> resched_valid_o);
  a_r11_stray_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_rsp_valid_i || !rsp_live) |=> !resched_valid_o);
endmodule

// File: tb/l1_prt_cache_tb_top.sv
module l1_prt_cache_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int LINE_W = 1024;
  localparam int N      = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0, req_resched = 1'b0;
  logic [31:0]       req_addr = '0, req_mask = '0;
  logic              req_accept, req_reject;
  logic              wb_valid, replay, mem_req_valid, resched_valid;
  logic [31:0]       wb_mask, mem_req_addr, resched_addr, resched_mask;
  logic [LINE_W-1:0] wb_data;
  logic [2:0]        mem_req_subid;
  logic              rsp_valid = 1'b0;
  logic [2:0]        rsp_subid = '0;
  logic [LINE_W-1:0] rsp_data = '0;

  always #10 clk = ~clk;

  l1_prt_cache dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_mask_i(req_mask),
    .req_resched_i(req_resched), .req_accept_o(req_accept), .req_reject_o(req_reject),
    .wb_valid_o(wb_valid), .wb_mask_o(wb_mask), .wb_data_o(wb_data),
    .replay_o(replay), .mem_req_valid_o(mem_req_valid), .mem_req_addr_o(mem_req_addr),
    .mem_req_subid_o(mem_req_subid), .mem_rsp_valid_i(rsp_valid),
    .mem_rsp_subid_i(rsp_subid), .mem_rsp_data_i(rsp_data),
    .resched_valid_o(resched_valid), .resched_addr_o(resched_addr),
    .resched_mask_o(resched_mask)
  );

  int n_chk = 0, n_fail = 0, now = 0;
  logic [31:0] rec_addr [N];
  logic [31:0] rec_mask [N];
  logic        rec_live [N];
  int          rec_due  [N];
  logic [31:0] rq_addr [$];
  logic [31:0] rq_mask [$];
  logic        acc_s, rej_s, wb_s, rp_s, rs_s;
  logic [2:0]  sub_s;

  function automatic logic [LINE_W-1:0] line_of(input logic [31:0] a);
    logic [LINE_W-1:0] r;
    for (int l = 0; l < 32; l++)
      r[l*32 +: 32] = ({a[31:7], 7'(l)} * 32'd2654435761) ^ 32'h5bd1e995;
    return r;
  endfunction

  function automatic logic [LINE_W-1:0] masked(input logic [LINE_W-1:0] d, input logic [31:0] m);
    logic [LINE_W-1:0] r;
    for (int l = 0; l < 32; l++) r[l*32 +: 32] = m[l] ? d[l*32 +: 32] : 32'd0;
    return r;
  endfunction

  function automatic logic [31:0] la(input int tag, input int set);
    return {21'(tag), 4'(set), 7'd0};
  endfunction

  task automatic chk(input logic ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic cyc(input logic rv, input logic [31:0] ra, input logic [31:0] rm,
                     input logic rr, input logic pv, input logic [2:0] ps);
    logic        exp_rs;
    logic [31:0] exp_ra, exp_rm, ba;
    logic [LINE_W-1:0] exp_d;
    ba = {ra[31:7], 7'd0};
    req_valid = rv; req_addr = ra; req_mask = rm; req_resched = rr;
    rsp_valid = pv; rsp_subid = ps;
    rsp_data  = pv ? line_of(rec_addr[ps]) : '0;
    exp_rs = pv && rec_live[ps];
    exp_ra = rec_addr[ps];
    exp_rm = rec_mask[ps];
    #1;
    acc_s = req_accept; rej_s = req_reject;
    if (rv) chk(acc_s ^ rej_s, "R1 exactly one of accept/reject", {acc_s, rej_s}, 2'b10);
    else    chk(!acc_s && !rej_s, "R1 idle gives no answer", {acc_s, rej_s}, 0);
    if (rv && rr) chk(acc_s, "R8 rescheduled load accepted", acc_s, 1);
    @(posedge clk);
    @(negedge clk);
    now++;
    req_valid = 1'b0; req_resched = 1'b0; rsp_valid = 1'b0;
    wb_s = wb_valid; rp_s = replay; rs_s = resched_valid; sub_s = mem_req_subid;
    if (rv && acc_s) begin
      chk(wb_s ^ rp_s, "R2 accepted request gives one outcome", {wb_s, rp_s}, 0);
      if (wb_s) begin
        exp_d = masked(line_of(ba), rm);
        chk(wb_data == exp_d && wb_mask == rm, "R3 hit data with lane masking",
            wb_data[63:0] ^ {32'd0, wb_mask}, exp_d[63:0] ^ {32'd0, rm});
      end
      if (rp_s) begin
        chk(mem_req_valid && mem_req_addr == ba && !rec_live[sub_s],
            "R4 miss request address/free subid", mem_req_addr, ba);
        rec_addr[sub_s] = ba; rec_mask[sub_s] = rm; rec_live[sub_s] = 1'b1;
        rec_due[sub_s]  = now + 3 + int'($urandom_range(0, 7));
      end
      if (rr) chk(wb_s, "R8 rescheduled load hits", wb_s, 1);
    end else begin
      chk(!wb_s && !rp_s && !mem_req_valid, "R1 no effect without acceptance",
          {wb_s, rp_s, mem_req_valid}, 0);
    end
    if (exp_rs) begin
      chk(rs_s && resched_addr == exp_ra && resched_mask == exp_rm,
          "R8 reschedule address/mask", {resched_addr, resched_mask}, {exp_ra, exp_rm});
      rec_live[ps] = 1'b0;
    end else begin
      chk(!rs_s, "R11 no reschedule without live entry", rs_s, 0);
    end
    if (rs_s) begin
      rq_addr.push_back(resched_addr);
      rq_mask.push_back(resched_mask);
    end
  endtask

  task automatic do_resched();
    logic [31:0] a, m;
    a = rq_addr.pop_front();
    m = rq_mask.pop_front();
    cyc(1'b1, a, m, 1'b1, 1'b0, 3'd0);
  endtask

  task automatic drain();
    for (int it = 0; it < 200; it++) begin
      int pick;
      pick = -1;
      if (rq_addr.size() > 0) begin
        do_resched();
      end else begin
        for (int i = 0; i < N; i++) if (rec_live[i] && pick < 0) pick = i;
        if (pick < 0) break;
        cyc(1'b0, 32'd0, 32'd0, 1'b0, 1'b1, 3'(pick));
      end
    end
  endtask

  localparam logic [31:0] FULL = 32'hFFFF_FFFF;

  initial begin
    logic [31:0] a_blk, b_blk, e_blk;
    logic [31:0] c_blk [5];
    logic [31:0] d_blk [3];
    int exp_sub [4];
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin
      rec_addr[i] = '0; rec_mask[i] = '0; rec_live[i] = 1'b0; rec_due[i] = 0;
    end
    a_blk = la(1, 1); b_blk = la(2, 1); e_blk = la(30, 4);
    for (int k = 0; k < 5; k++) c_blk[k] = la(10 + k, 2);
    for (int k = 0; k < 3; k++) d_blk[k] = la(20 + k, 3);

    repeat (3) @(negedge clk);
    chk(!wb_valid && !replay && !mem_req_valid && !resched_valid && !req_accept,
        "R12 outputs idle in reset", {wb_valid, replay, mem_req_valid, resched_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    cyc(1'b1, a_blk | 32'h25, FULL, 1'b0, 1'b0, 3'd0);
    chk(rp_s && sub_s == 3'd0, "R12 first lookup misses, R4 subid 0", {rp_s, sub_s}, 4'b1000);
    cyc(1'b1, a_blk, FULL, 1'b0, 1'b0, 3'd0);
    chk(rej_s, "R7 duplicate outstanding miss rejected", rej_s, 1);
    cyc(1'b1, b_blk, FULL, 1'b0, 1'b0, 3'd0);
    chk(rp_s && sub_s == 3'd1, "R4 next subid is 1", sub_s, 1);
    cyc(1'b0, 32'd0, 32'd0, 1'b0, 1'b1, 3'd0);
    chk(rs_s && resched_addr == a_blk, "R8 fill reschedules A", resched_addr, a_blk);
    cyc(1'b0, 32'd0, 32'd0, 1'b0, 1'b1, 3'd6);
    chk(!rs_s, "R11 stray subid ignored", rs_s, 0);
    void'(rq_addr.pop_front()); void'(rq_mask.pop_front());
    cyc(1'b1, a_blk, 32'h0000_FFFF, 1'b1, 1'b0, 3'd0);
    chk(wb_s && wb_data[1023:512] == '0, "R3 upper lanes zero", wb_data[1023:960], 0);

    exp_sub = '{0, 2, 3, 4};
    for (int k = 0; k < 4; k++) begin
      cyc(1'b1, c_blk[k], FULL, 1'b0, 1'b0, 3'd0);
      chk(rp_s && sub_s == 3'(exp_sub[k]), "R4 lowest free subid", sub_s, exp_sub[k]);
    end
    cyc(1'b1, c_blk[4], FULL, 1'b0, 1'b0, 3'd0);
    chk(rej_s, "R6 all ways pending rejects miss", rej_s, 1);
    for (int k = 0; k < 3; k++) begin
      cyc(1'b1, d_blk[k], FULL, 1'b0, 1'b0, 3'd0);
      chk(rp_s && sub_s == 3'(5 + k), "R4 subid fills upper entries", sub_s, 5 + k);
    end
    cyc(1'b1, e_blk, FULL, 1'b0, 1'b0, 3'd0);
    chk(rej_s, "R5 full table rejects miss", rej_s, 1);
    cyc(1'b1, a_blk, 32'hF0F0_1234, 1'b0, 1'b0, 3'd0);
    chk(acc_s && wb_s, "R1 hit accepted with table full", {acc_s, wb_s}, 3);

    cyc(1'b0, 32'd0, 32'd0, 1'b0, 1'b1, 3'd0);
    cyc(1'b0, 32'd0, 32'd0, 1'b0, 1'b1, 3'd4);
    cyc(1'b0, 32'd0, 32'd0, 1'b0, 1'b1, 3'd2);
    cyc(1'b0, 32'd0, 32'd0, 1'b0, 1'b1, 3'd3);
    cyc(1'b1, c_blk[4], FULL, 1'b0, 1'b0, 3'd0);
    chk(rej_s, "R9 locked lines not evicted", rej_s, 1);
    for (int k = 0; k < 4; k++) begin
      do_resched();
      chk(wb_s, "R9 locked line hit releases lock", wb_s, 1);
    end
    cyc(1'b1, c_blk[4], FULL, 1'b0, 1'b0, 3'd0);
    chk(acc_s && rp_s && sub_s == 3'd0, "R10 miss accepted after unlock", {acc_s, rp_s, sub_s}, 5'b11000);
    cyc(1'b0, 32'd0, 32'd0, 1'b0, 1'b1, 3'd0);
    do_resched();
    cyc(1'b1, c_blk[0], FULL, 1'b0, 1'b0, 3'd0);
    chk(rp_s, "R10 way 0 was the victim", rp_s, 1);
    cyc(1'b1, c_blk[1], FULL, 1'b0, 1'b0, 3'd0);
    chk(wb_s, "R10 way 1 kept", wb_s, 1);
    drain();

    for (int c = 0; c < 3000; c++) begin
      logic rv, rr, pv;
      logic [31:0] ra, rm;
      int pk, off;
      rv = 1'b0; rr = 1'b0; ra = '0; rm = '0; pv = 1'b0; pk = 0;
      if (rq_addr.size() > 0 && $urandom_range(0, 1) == 1) begin
        rv = 1'b1; rr = 1'b1; ra = rq_addr.pop_front(); rm = rq_mask.pop_front();
      end else if ($urandom_range(0, 9) < 6) begin
        rv = 1'b1;
        ra = la(int'($urandom_range(0, 5)), int'($urandom_range(0, 1))) | 32'($urandom_range(0, 127));
        rm = $urandom;
      end
      off = int'($urandom_range(0, 7));
      for (int k = 0; k < N; k++) begin
        int i;
        i = (off + k) % N;
        if (!pv && rec_live[i] && rec_due[i] <= now) begin pv = 1'b1; pk = i; end
      end
      cyc(rv, ra, rm, rr, pv, 3'(pk));
    end
    drain();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule